// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches a bank of 32 already-synchronised pin inputs, grouped as four ports of eight pins, and turns selected pin events into one interrupt request for the bank. Software gives each pin a trigger type: rising edge, falling edge, either edge, high level or low level. A detected condition sets that pin's status bit. Status bits are cleared by writing ones to a clear register. The bank request is raised while any status bit has its enable bit set.

Each port has four register slots in a simple write bus: a type word, a status word, an enable word and a write-one-to-clear word. Enable also has a masked alias, so single bits can change without a read-modify-write. Reads are combinational from a separate read address. Edge detection compares each pin's present sample with the sample held from the previous cycle.

Top module: `gpio_irq_bank`

## Requirements
- R1: Reset clears every type, status and enable bit, and holds irq_o low; status reads 0 while reset is asserted.
- R2: The type word of port n is at byte address 0x60+4n and keeps bits 23:0 (bits 31:24 read as 0). For pin p, bit p selects high/rising, bit 8+p selects edge mode and bit 16+p selects both edges. The codes are: rising 0x000101, falling 0x000100, both 0x010100, high level 0x000001, low level 0x000000, each shifted left by p.
- R3: An edge-mode pin sets its status bit at the first clock edge where its sample differs from the previous cycle's sample in the selected direction (rising, falling or either). No other edge pattern sets it.
- R4: A level-mode pin sets its status bit at each clock edge where its sample is at the selected active level.
- R5: Writing the clear word at 0x70+4n clears each status bit whose data bit is 1. Data bits that are 0 leave status unchanged.
- R6: For an edge-mode pin, a new edge in the same cycle as a clear keeps the status bit set. An edge arriving after a clear sets the bit again.
- R7: For a level-mode pin, a clear takes effect for one cycle. If the level is still active, the bit is set again at the next clock edge.
- R8: Enable for port n is written directly at 0x50+4n using bits 7:0. A write to the masked alias at MASK_OFS+0x50+4n changes only the enable bits whose mask bit (data bits 15:8) is 1, loading them from data bits 7:0.
- R9: irq_o is the OR, over all ports, of status AND enable. It follows register changes in the cycle after the clock edge that caused them.
- R10: Status is read at 0x40+4n. A bus write to it does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 32 | Synchronised pin samples, pin 8n+p is port n pin p |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Bank interrupt request |

## Verification
A software clear and a fresh pin event can land on the same clock edge. The edge and level cases resolve this collision in opposite ways. The bench provokes an edge collision by driving a rising pin in the same cycle as a clear of that bit; it then requires the bit to survive. For a level collision it clears a pin whose level is still active, reads status straight after the clear edge expecting 0, then reads again one cycle later expecting the bit set.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int PORT_W = 8;
  localparam int TYPE_W = 3 * PORT_W;

  typedef struct packed {
    logic both;
    logic edge_mode;
    logic sel_hi;
  } pin_cfg_t;

  typedef enum logic [1:0] {
    RS_NONE = 2'd0,
    RS_STAT = 2'd1,
    RS_EN   = 2'd2,
    RS_TYPE = 2'd3
  } rd_sel_e;

  function automatic pin_cfg_t f_pin_cfg(input logic [TYPE_W-1:0] word, input int p);
    pin_cfg_t c;
    c.sel_hi    = word[p];
    c.edge_mode = word[PORT_W + p];
    c.both      = word[2*PORT_W + p];
    return c;
  endfunction

  function automatic logic f_hit(input pin_cfg_t c, input logic cur, input logic prv);
    logic r;
    if (c.edge_mode) begin
      if (c.both)        r = cur ^ prv;
      else if (c.sel_hi) r = cur & ~prv;
      else               r = ~cur & prv;
    end else begin
      r = c.sel_hi ? cur : ~cur;
    end
    return r;
  endfunction

  function automatic logic [PORT_W-1:0] f_masked(input logic [PORT_W-1:0] old,
                                                  input logic [2*PORT_W-1:0] d);
    logic [PORT_W-1:0] m;
    m = d[2*PORT_W-1:PORT_W];
    return (old & ~m) | (d[PORT_W-1:0] & m);
  endfunction

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 12,
  parameter int MASK_OFS  = 'h080
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [NUM_PORTS-1:0] we_type,
  output logic [NUM_PORTS-1:0] we_stat,
  output logic [NUM_PORTS-1:0] we_en,
  output logic [NUM_PORTS-1:0] we_en_msk,
  output logic [NUM_PORTS-1:0] we_clr,
  output logic [1:0]           rd_port,
  output rd_sel_e              rd_sel
);
  localparam int SL_STAT = 'h040 >> 4;
  localparam int SL_EN   = 'h050 >> 4;
  localparam int SL_TYPE = 'h060 >> 4;
  localparam int SL_CLR  = 'h070 >> 4;
  localparam int SL_MEN  = (MASK_OFS + 'h050) >> 4;

  logic [ADDR_W-5:0] w_slot, r_slot;
  logic [1:0]        w_port;
  logic [1:0]        unused_lo;

  assign w_slot    = wr_addr[ADDR_W-1:4];
  assign r_slot    = rd_addr[ADDR_W-1:4];
  assign w_port    = wr_addr[3:2];
  assign rd_port   = rd_addr[3:2];
  assign unused_lo = wr_addr[1:0] ^ rd_addr[1:0];

  for (genvar n = 0; n < NUM_PORTS; n++) begin : g_strobe
    logic hit_port;
    assign hit_port     = wr_en && (int'(w_port) == n);
    assign we_stat[n]   = hit_port && (int'(w_slot) == SL_STAT);
    assign we_en[n]     = hit_port && (int'(w_slot) == SL_EN);
    assign we_type[n]   = hit_port && (int'(w_slot) == SL_TYPE);
    assign we_clr[n]    = hit_port && (int'(w_slot) == SL_CLR);
    assign we_en_msk[n] = hit_port && (int'(w_slot) == SL_MEN);
  end

  always_comb begin
    rd_sel = RS_NONE;
    if (int'(rd_port) < NUM_PORTS) begin
      if (int'(r_slot) == SL_STAT)                                  rd_sel = RS_STAT;
      else if (int'(r_slot) == SL_EN || int'(r_slot) == SL_MEN)     rd_sel = RS_EN;
      else if (int'(r_slot) == SL_TYPE)                             rd_sel = RS_TYPE;
      else                                                          rd_sel = RS_NONE;
    end
  end

  // At most one register slot is hit by one bus write (R8, R10)
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_type, we_stat, we_en, we_en_msk, we_clr}));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pins,
  input  logic [TYPE_W-1:0] wdata,
  input  logic              we_type,
  input  logic              we_stat,
  input  logic              we_en,
  input  logic              we_en_msk,
  input  logic              we_clr,
  output logic [TYPE_W-1:0] type_q,
  output logic [PORT_W-1:0] status_q,
  output logic [PORT_W-1:0] enable_q,
  output logic [PORT_W-1:0] pend
);
  logic [PORT_W-1:0] prev_q;
  logic [PORT_W-1:0] hit;
  logic [PORT_W-1:0] edge_m;
  logic [PORT_W-1:0] lvl_m;
  logic [PORT_W-1:0] clr_hit;
  logic [PORT_W-1:0] status_d;

  assign clr_hit = we_clr ? wdata[PORT_W-1:0] : '0;

  for (genvar p = 0; p < PORT_W; p++) begin : g_pin
    pin_cfg_t cfg;
    assign cfg       = f_pin_cfg(type_q, p);
    assign edge_m[p] = cfg.edge_mode;
    assign lvl_m[p]  = ~cfg.edge_mode;
    assign hit[p]    = f_hit(cfg, pins[p], prev_q[p]);

    always_comb begin
      if (cfg.edge_mode) status_d[p] = (status_q[p] & ~clr_hit[p]) | hit[p];
      else if (clr_hit[p]) status_d[p] = 1'b0;
      else                 status_d[p] = status_q[p] | hit[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
      enable_q <= '0;
      type_q   <= '0;
    end else begin
      prev_q   <= pins;
      status_q <= status_d;
      if (we_type)        type_q   <= wdata;
      if (we_en)          enable_q <= wdata[PORT_W-1:0];
      else if (we_en_msk) enable_q <= f_masked(enable_q, wdata[2*PORT_W-1:0]);
    end
  end

  assign pend = status_q & enable_q;

  // A status bit only rises when its trigger fired (R3, R4)
  p_only_trigger_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(hit)) == '0));

  // Edge arriving with a clear keeps the bit (R6)
  p_edge_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr |=> ((status_q & $past(hit & edge_m)) == $past(hit & edge_m)));

  // Clear of a level pin drops the bit for one cycle (R7)
  p_level_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr |=> ((status_q & $past(lvl_m & wdata[PORT_W-1:0])) == '0));

  // Masked enable write leaves unmasked bits alone (R8)
  p_masked_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_en_msk && !we_en) |=>
      (((enable_q ^ $past(enable_q)) & ~$past(wdata[2*PORT_W-1:PORT_W])) == '0));

  // A bus write to status is ignored (R10)
  p_stat_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we_stat && !we_clr && (hit == '0)) |=> (status_q == $past(status_q)));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 12,
  parameter int MASK_OFS  = 'h080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       pins_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq_o
);
  localparam int NPINS = NUM_PORTS * PORT_W;

  logic [NUM_PORTS-1:0] we_type, we_stat, we_en, we_en_msk, we_clr;
  logic [1:0]           rd_port;
  rd_sel_e              rd_sel;

  logic [TYPE_W-1:0] type_a   [NUM_PORTS];
  logic [PORT_W-1:0] status_a [NUM_PORTS];
  logic [PORT_W-1:0] enable_a [NUM_PORTS];
  logic [NPINS-1:0]  pend_all;
  logic [NPINS-1:0]  en_all;
  logic [7:0]        unused_hi;

  assign unused_hi = wr_data[31:24];

  gpio_irq_decode #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .we_type(we_type), .we_stat(we_stat), .we_en(we_en), .we_en_msk(we_en_msk),
    .we_clr(we_clr), .rd_port(rd_port), .rd_sel(rd_sel)
  );

  for (genvar n = 0; n < NUM_PORTS; n++) begin : g_port
    gpio_irq_port u_port (
      .clk(clk), .rst_n(rst_n),
      .pins(pins_i[n*PORT_W +: PORT_W]),
      .wdata(wr_data[TYPE_W-1:0]),
      .we_type(we_type[n]), .we_stat(we_stat[n]), .we_en(we_en[n]),
      .we_en_msk(we_en_msk[n]), .we_clr(we_clr[n]),
      .type_q(type_a[n]), .status_q(status_a[n]), .enable_q(enable_a[n]),
      .pend(pend_all[n*PORT_W +: PORT_W])
    );
    assign en_all[n*PORT_W +: PORT_W] = enable_a[n];
  end

  assign irq_o = |pend_all;

  always_comb begin
    rd_data = '0;
    if (int'(rd_port) < NUM_PORTS) begin
      case (rd_sel)
        RS_STAT: rd_data[PORT_W-1:0] = status_a[rd_port];
        RS_EN:   rd_data[PORT_W-1:0] = enable_a[rd_port];
        RS_TYPE: rd_data[TYPE_W-1:0] = type_a[rd_port];
        default: rd_data = '0;
      endcase
    end
  end

  // With every enable bit off the request stays low (R9)
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |-> !irq_o);

  // Reset state reaches the request line (R1)
  always_comb begin
    if (!rst_n) p_reset_quiet_r1: assert (!irq_o);
  end

endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins_i = '0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  // vector: {both, edge, sel} code, previous pin, new pin, expected status bit
  typedef struct packed {
    logic [2:0] code;
    logic       v0;
    logic       v1;
    logic       exp_st;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{3'b011, 1'b0, 1'b1, 1'b1},  // rising, rises
    '{3'b011, 1'b1, 1'b0, 1'b0},  // rising, falls
    '{3'b010, 1'b1, 1'b0, 1'b1},  // falling, falls
    '{3'b010, 1'b0, 1'b1, 1'b0},  // falling, rises
    '{3'b110, 1'b0, 1'b1, 1'b1},  // both, rises
    '{3'b110, 1'b1, 1'b0, 1'b1},  // both, falls
    '{3'b110, 1'b1, 1'b1, 1'b0},  // both, steady
    '{3'b001, 1'b0, 1'b1, 1'b1},  // high level, high
    '{3'b001, 1'b1, 1'b0, 1'b0},  // high level, low
    '{3'b000, 1'b1, 1'b0, 1'b1},  // low level, low
    '{3'b000, 1'b0, 1'b1, 1'b0}   // low level, high
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(12'h044, v); check("R1 status in reset", v, 32'h0);
    rd(12'h060, v); check("R1 type in reset", v, 32'h0);
    rd(12'h050, v); check("R1 enable in reset", v, 32'h0);
    check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    rst_n = 1'b1;
    tick();

    // R2: type readback keeps 23:0
    wr(12'h060, 32'hAB12_3456);
    rd(12'h060, v); check("R2 type readback", v, 32'h0012_3456);
    wr(12'h060, 32'h0);

    // table over port 1 pin 3; only that bit enabled
    wr(12'h054, 32'h08);
    for (int i = 0; i < NVEC; i++) begin
      pins_i[11] = VECS[i].v0;
      wr(12'h064, {8'h0, 7'h0, VECS[i].code[2], 3'b0, 4'h0, VECS[i].code[1], 3'b0,
                   4'h0, VECS[i].code[0], 3'b0});
      tick();
      wr(12'h074, 32'h08);
      pins_i[11] = VECS[i].v1;
      tick();
      rd(12'h044, v);
      check((VECS[i].code[1]) ? "R3 edge vector" : "R4 level vector",
            {31'b0, v[3]}, {31'b0, VECS[i].exp_st});
      check("R9 irq follows vector", {31'b0, irq_o}, {31'b0, VECS[i].exp_st});
    end
    wr(12'h054, 32'h0);

    // R5: clear semantics on port 2 with rising type
    wr(12'h068, 32'h0000_FFFF);
    wr(12'h078, 32'hFF);
    pins_i[23:16] = 8'hFF;
    tick();
    rd(12'h048, v); check("R3 rising all pins", v, 32'hFF);
    wr(12'h078, 32'h0F);
    rd(12'h048, v); check("R5 clear ones", v, 32'hF0);
    wr(12'h078, 32'h00);
    rd(12'h048, v); check("R5 clear zeros ignored", v, 32'hF0);
    // R10: write to status ignored
    wr(12'h048, 32'h00);
    rd(12'h048, v); check("R10 status write ignored", v, 32'hF0);

    // R6: edge same cycle as clear
    pins_i[23:16] = 8'h00;
    tick();
    pins_i[16] = 1'b1;
    wr(12'h078, 32'hFF);
    rd(12'h048, v); check("R6 edge beats clear", v, 32'h01);
    wr(12'h078, 32'h01);
    rd(12'h048, v); check("R5 clear edge bit", v, 32'h00);
    pins_i[16] = 1'b0;
    tick();
    pins_i[16] = 1'b1;
    tick();
    rd(12'h048, v); check("R6 edge after clear sets", v, 32'h01);

    // R7: level high on port 3, clear while active
    pins_i[31:24] = 8'h01;
    wr(12'h06C, 32'h0000_00FF);
    tick();
    wr(12'h07C, 32'hFF);
    rd(12'h04C, v); check("R7 clear wins one cycle", v, 32'h00);
    tick();
    rd(12'h04C, v); check("R7 level sets again", v, 32'h01);

    // R8: direct and masked enable
    wr(12'h050, 32'hA5);
    rd(12'h050, v); check("R8 direct enable", v, 32'hA5);
    wr(12'h0D0, 32'h0000_0F0A);
    rd(12'h050, v); check("R8 masked enable", v, 32'hAA);
    check("R9 irq port0 level low", {31'b0, irq_o}, 32'h1);

    // R9: bank OR across ports
    wr(12'h050, 32'h00);
    check("R9 irq all disabled", {31'b0, irq_o}, 32'h0);
    wr(12'h05C, 32'h01);
    check("R9 irq port3 pending", {31'b0, irq_o}, 32'h1);
    wr(12'h05C, 32'h02);
    check("R9 irq enable without status", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule